// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block holds the general-purpose registers of a small 8-bit processor core. Storage is split into four banks of eight byte-wide registers. A two-bit bank register picks which bank all register-side accesses use, and a bank-select operation loads that register with a value from 0 to 3. Inside the active bank, a register is named by a 3-bit code. The registers are also grouped into four 16-bit pairs, each named by a 2-bit code.

The register side has two independent byte read ports and one pair read port. It takes a byte write, a pair write, and an exchange that swaps the accumulator pair with another pair in one cycle. The same 32 bytes also appear as ordinary data memory at a 16-bit address window from FEE0h to FEFFh. The memory side reads and writes any bank, whatever bank is active. All reads are combinational, so a value written at one clock edge can be read in the next cycle. Flag logic and arithmetic belong elsewhere in the core.

Top module: `banked_regfile`

## Requirements
- R1: After reset, all 32 registers read as 00h and the active bank is 0.
- R2: Byte register codes map as 000=X, 001=A, 010=C, 011=B, 100=E, 101=D, 110=L, 111=H in the active bank. The two byte read ports work independently. A byte write is readable in the next cycle.
- R3: Pair codes map as 00=AX, 01=BC, 10=DE, 11=HL. The pair read port returns the odd-coded register (A, B, D, H) in bits [15:8] and the even-coded register (X, C, E, L) in bits [7:0].
- R4: A pair write stores bits [7:0] into the even-coded register and bits [15:8] into the odd-coded register of the pair, both in the active bank.
- R5: A bank-select operation loads the active bank from bank_val at the clock edge. A register-side write in that same cycle goes to the bank that was active before the edge.
- R6: An exchange with pair code 01, 10 or 11 swaps AX with that pair in one cycle. An exchange with code 00 changes nothing.
- R7: The memory window places bank b at address FEF8h - 8*b through FEFFh - 8*b, and register code n at that base + n. The memory side reads and writes any bank, whatever bank is active, and sees the same bytes as the register side.
- R8: An address outside FEE0h..FEFFh gives mem_hit=0 and mem_rdata=00h, and a memory write there changes no register.
- R9: If a memory write and a register-side write hit the same byte in one cycle, the register-side value is stored. If they hit different bytes, both are stored.
- R10: Among register-side writes to the same byte in one cycle, the exchange overrides the pair write, and the pair write overrides the byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Bank-select operation |
| bank_val | input | 2 | New active bank |
| bank_o | output | 2 | Current active bank |
| rd_a_code | input | 3 | Register code, read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_code | input | 3 | Register code, read port B |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_code | input | 2 | Pair code for the pair read |
| rd_pair_data | output | 16 | Pair read data |
| wr_byte_en | input | 1 | Byte write enable |
| wr_byte_code | input | 3 | Byte write register code |
| wr_byte_data | input | 8 | Byte write data |
| wr_pair_en | input | 1 | Pair write enable |
| wr_pair_code | input | 2 | Pair write code |
| wr_pair_data | input | 16 | Pair write data |
| xchg_en | input | 1 | Exchange AX with a pair |
| xchg_code | input | 2 | Pair to exchange with AX |
| mem_addr | input | 16 | Memory-side address |
| mem_we | input | 1 | Memory-side write strobe |
| mem_wdata | input | 8 | Memory-side write data |
| mem_rdata | output | 8 | Memory-side read data |
| mem_hit | output | 1 | Address falls in the register window |

## Verification
The bench aims at the bank-to-address order of the window. A design that placed bank 0 at the low end would return data from the wrong bank on memory reads. It also checks which byte of a pair is low: a swapped design returns pair values with their bytes reversed. Same-cycle collisions get directed tests: a bank switch together with a write, a memory write together with a register write, and a pair write together with a byte write or an exchange. A design that gave the wrong side priority would leave the losing value in storage. Addresses just outside both ends of the window are written, to catch a window that is off by one or that aliases.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int REGS_PER_BANK = 8;
  localparam int CODE_W        = 3;
  localparam int PAIR_W        = 2;

  typedef enum logic [CODE_W-1:0] {
    RC_X = 3'd0, RC_A = 3'd1, RC_C = 3'd2, RC_B = 3'd3,
    RC_E = 3'd4, RC_D = 3'd5, RC_L = 3'd6, RC_H = 3'd7
  } reg_code_e;

  typedef enum logic [PAIR_W-1:0] {
    PC_AX = 2'd0, PC_BC = 2'd1, PC_DE = 2'd2, PC_HL = 2'd3
  } pair_code_e;

  // Register code of one half of a pair: hi=0 gives the even (low) byte.
  function automatic logic [CODE_W-1:0] pair_reg(input logic [PAIR_W-1:0] p,
                                                 input logic hi);
    return {p, hi};
  endfunction
endpackage

// File: rtl/rf_bank_select.sv
module rf_bank_select #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [BANK_W-1:0] sel_val,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= '0;
    else if (sel_we) bank_q <= sel_val;
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> bank_q == $past(sel_val)); // R5
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> bank_q == $past(bank_q)); // R5
endmodule

// File: rtl/rf_window_decode.sv
module rf_window_decode #(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     WIN_BASE = 16'hFEE0,
  parameter int              IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  import rf_pkg::*;
  localparam int TOTAL = 1 << IDX_W;

  logic [ADDR_W-1:0] offset;

  // Banks are laid out downward: the highest slot of the window is bank 0.
  function automatic logic [IDX_W-1:0] window_slot(input logic [IDX_W-1:0] off);
    return {~off[IDX_W-1:CODE_W], off[CODE_W-1:0]};
  endfunction

  always_comb begin
    offset = addr - ADDR_W'(WIN_BASE);
    hit    = (addr >= ADDR_W'(WIN_BASE)) && (offset < ADDR_W'(TOTAL));
    idx    = window_slot(offset[IDX_W-1:0]);
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic                byte_we,
  input  logic [2:0]          byte_code,
  input  logic [DATA_W-1:0]   byte_data,
  input  logic                pair_we,
  input  logic [1:0]          pair_code,
  input  logic [2*DATA_W-1:0] pair_data,
  input  logic                xchg_en,
  input  logic [1:0]          xchg_code,
  input  logic                mem_we,
  input  logic [IDX_W-1:0]    mem_idx,
  input  logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W-1:0]   regs_q [1<<IDX_W]
);
  import rf_pkg::*;
  localparam int TOTAL = 1 << IDX_W;

  logic [DATA_W-1:0] regs_d [TOTAL];
  logic [IDX_W-1:0]  byte_idx, pair_lo_idx, pair_hi_idx;
  logic [IDX_W-1:0]  ax_lo_idx, ax_hi_idx, xp_lo_idx, xp_hi_idx;
  logic [DATA_W-1:0] ax_lo, ax_hi, xp_lo, xp_hi;
  logic              xchg_fire, byte_only, pair_only, mem_only;

  assign byte_idx    = {bank_i, byte_code};
  assign pair_lo_idx = {bank_i, pair_reg(pair_code, 1'b0)};
  assign pair_hi_idx = {bank_i, pair_reg(pair_code, 1'b1)};
  assign ax_lo_idx   = {bank_i, pair_reg(2'b00, 1'b0)};
  assign ax_hi_idx   = {bank_i, pair_reg(2'b00, 1'b1)};
  assign xp_lo_idx   = {bank_i, pair_reg(xchg_code, 1'b0)};
  assign xp_hi_idx   = {bank_i, pair_reg(xchg_code, 1'b1)};
  assign ax_lo       = regs_q[ax_lo_idx];
  assign ax_hi       = regs_q[ax_hi_idx];
  assign xp_lo       = regs_q[xp_lo_idx];
  assign xp_hi       = regs_q[xp_hi_idx];
  assign xchg_fire   = xchg_en && (xchg_code != 2'b00);
  assign byte_only   = byte_we && !pair_we && !xchg_fire;
  assign pair_only   = pair_we && !xchg_fire;
  assign mem_only    = mem_we && !byte_we && !pair_we && !xchg_fire;

  // Per-byte next value; later terms override earlier ones (memory lowest).
  for (genvar i = 0; i < TOTAL; i++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic [DATA_W-1:0] nxt;
    always_comb begin
      nxt = regs_q[i];
      if (mem_we  && mem_idx == SLOT)     nxt = mem_wdata;
      if (byte_we && byte_idx == SLOT)    nxt = byte_data;
      if (pair_we && pair_lo_idx == SLOT) nxt = pair_data[DATA_W-1:0];
      if (pair_we && pair_hi_idx == SLOT) nxt = pair_data[2*DATA_W-1:DATA_W];
      if (xchg_fire) begin
        if (SLOT == ax_lo_idx) nxt = xp_lo;
        if (SLOT == ax_hi_idx) nxt = xp_hi;
        if (SLOT == xp_lo_idx) nxt = ax_lo;
        if (SLOT == xp_hi_idx) nxt = ax_hi;
      end
    end
    assign regs_d[i] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TOTAL; j++) regs_q[j] <= '0;
    end else begin
      regs_q <= regs_d;
    end
  end

  AST_BYTE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_only |=> regs_q[$past(byte_idx)] == $past(byte_data)); // R2
  AST_PAIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_only |=> {regs_q[$past(pair_hi_idx)], regs_q[$past(pair_lo_idx)]}
                  == $past(pair_data)); // R4
  AST_XCHG_AX: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_fire |=> {regs_q[$past(ax_hi_idx)], regs_q[$past(ax_lo_idx)]}
                  == $past({xp_hi, xp_lo})); // R6
  AST_XCHG_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_fire |=> {regs_q[$past(xp_hi_idx)], regs_q[$past(xp_lo_idx)]}
                  == $past({ax_hi, ax_lo})); // R6
  AST_MEM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_only |=> regs_q[$past(mem_idx)] == $past(mem_wdata)); // R7
  AST_REG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && byte_only && mem_idx == byte_idx)
      |=> regs_q[$past(byte_idx)] == $past(byte_data)); // R9
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int          NUM_BANKS = 4,
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] WIN_BASE  = 16'hFEE0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_we,
  input  logic [1:0]          bank_val,
  output logic [1:0]          bank_o,
  input  logic [2:0]          rd_a_code,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [2:0]          rd_b_code,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic [1:0]          rd_pair_code,
  output logic [2*DATA_W-1:0] rd_pair_data,
  input  logic                wr_byte_en,
  input  logic [2:0]          wr_byte_code,
  input  logic [DATA_W-1:0]   wr_byte_data,
  input  logic                wr_pair_en,
  input  logic [1:0]          wr_pair_code,
  input  logic [2*DATA_W-1:0] wr_pair_data,
  input  logic                xchg_en,
  input  logic [1:0]          xchg_code,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_we,
  input  logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_hit
);
  import rf_pkg::*;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = BANK_W + CODE_W;
  localparam int TOTAL  = NUM_BANKS * REGS_PER_BANK;

  logic [BANK_W-1:0]       bank_q;
  logic [IDX_W-1:0]        mem_idx;
  logic                    mem_wr_hit;
  logic                    reg_side_busy;
  logic [DATA_W-1:0]       regs_q [TOTAL];
  logic [TOTAL*DATA_W-1:0] regs_flat;

  rf_bank_select #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .sel_we(bank_we),
    .sel_val(bank_val[BANK_W-1:0]), .bank_q(bank_q)
  );

  rf_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)) u_dec (
    .addr(mem_addr), .hit(mem_hit), .idx(mem_idx)
  );

  assign mem_wr_hit = mem_we && mem_hit;

  rf_storage #(.DATA_W(DATA_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .bank_i(bank_q),
    .byte_we(wr_byte_en), .byte_code(wr_byte_code), .byte_data(wr_byte_data),
    .pair_we(wr_pair_en), .pair_code(wr_pair_code), .pair_data(wr_pair_data),
    .xchg_en(xchg_en), .xchg_code(xchg_code),
    .mem_we(mem_wr_hit), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
    .regs_q(regs_q)
  );

  for (genvar k = 0; k < TOTAL; k++) begin : g_flat
    assign regs_flat[k*DATA_W +: DATA_W] = regs_q[k];
  end

  assign bank_o       = 2'(bank_q);
  assign rd_a_data    = regs_q[{bank_q, rd_a_code}];
  assign rd_b_data    = regs_q[{bank_q, rd_b_code}];
  assign rd_pair_data = {regs_q[{bank_q, pair_reg(rd_pair_code, 1'b1)}],
                         regs_q[{bank_q, pair_reg(rd_pair_code, 1'b0)}]};
  assign mem_rdata    = mem_hit ? regs_q[mem_idx] : '0;

  assign reg_side_busy = wr_byte_en || wr_pair_en || (xchg_en && xchg_code != 2'b00);

  AST_WINDOW_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit && mem_idx == {bank_q, rd_a_code}) |-> mem_rdata == rd_a_data); // R7
  AST_OUTSIDE_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_hit && !reg_side_busy) |=> $stable(regs_flat)); // R8
  AST_XCHG_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_en && xchg_code == 2'b00 && !wr_byte_en && !wr_pair_en && !mem_we)
      |=> $stable(regs_flat)); // R6
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bank_we;
  logic [1:0]  bank_val, bank_o;
  logic [2:0]  rd_a_code, rd_b_code;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [1:0]  rd_pair_code;
  logic [15:0] rd_pair_data;
  logic        wr_byte_en;
  logic [2:0]  wr_byte_code;
  logic [7:0]  wr_byte_data;
  logic        wr_pair_en;
  logic [1:0]  wr_pair_code;
  logic [15:0] wr_pair_data;
  logic        xchg_en;
  logic [1:0]  xchg_code;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_val(bank_val), .bank_o(bank_o),
    .rd_a_code(rd_a_code), .rd_a_data(rd_a_data), .rd_b_code(rd_b_code), .rd_b_data(rd_b_data),
    .rd_pair_code(rd_pair_code), .rd_pair_data(rd_pair_data),
    .wr_byte_en(wr_byte_en), .wr_byte_code(wr_byte_code), .wr_byte_data(wr_byte_data),
    .wr_pair_en(wr_pair_en), .wr_pair_code(wr_pair_code), .wr_pair_data(wr_pair_data),
    .xchg_en(xchg_en), .xchg_code(xchg_code),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit)
  );

  // {bank, code, value}: written through memory, read back through registers.
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 3'd1, 8'h11}, {2'd0, 3'd7, 8'h22}, {2'd1, 3'd0, 8'h33}, {2'd1, 3'd6, 8'h44},
    {2'd2, 3'd2, 8'h55}, {2'd2, 3'd5, 8'h66}, {2'd3, 3'd0, 8'h77}, {2'd3, 3'd3, 8'h88}
  };

  // Bank 0 is the top eight bytes of FEE0..FEFF, bank 3 the bottom eight.
  function automatic logic [15:0] win_addr(input int bank, input int code);
    return 16'hFEFF - 16'(8 * bank) - 16'(7 - code);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bank_we = 0; wr_byte_en = 0; wr_pair_en = 0; xchg_en = 0; mem_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic set_bank(input logic [1:0] b);
    bank_we = 1; bank_val = b; tick();
  endtask

  task automatic mem_peek(input string req, input logic [15:0] a, input logic [7:0] exp);
    mem_addr = a; #1;
    check(req, {8'h00, mem_rdata}, {8'h00, exp});
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    bank_val = 0; rd_a_code = 0; rd_b_code = 0; rd_pair_code = 0;
    wr_byte_code = 0; wr_byte_data = 0; wr_pair_code = 0; wr_pair_data = 0;
    xchg_code = 0; mem_addr = 16'hFEE0; mem_wdata = 0;
    do_reset();

    // R1: reset state
    #1;
    check("R1 bank", {14'd0, bank_o}, 16'd0);
    check("R1 AX", rd_pair_data, 16'h0000);
    mem_peek("R1 FEE0", 16'hFEE0, 8'h00);
    mem_peek("R1 FEFF", 16'hFEFF, 8'h00);

    // R7: table walk, memory-side writes then register-side reads
    for (int i = 0; i < 8; i++) begin
      mem_addr = win_addr(int'(VEC[i][12:11]), int'(VEC[i][10:8]));
      mem_wdata = VEC[i][7:0]; mem_we = 1;
      tick();
    end
    for (int i = 0; i < 8; i++) begin
      set_bank(VEC[i][12:11]);
      rd_a_code = VEC[i][10:8]; rd_b_code = VEC[i][10:8]; #1;
      check("R7 port A", {8'h00, rd_a_data}, {8'h00, VEC[i][7:0]});
      check("R7 port B", {8'h00, rd_b_data}, {8'h00, VEC[i][7:0]});
      mem_peek("R7 mem read", win_addr(int'(VEC[i][12:11]), int'(VEC[i][10:8])), VEC[i][7:0]);
    end

    // R2: byte writes in bank 1, X..H = A0..A7
    set_bank(2'd1);
    for (int c = 0; c < 8; c++) begin
      wr_byte_en = 1; wr_byte_code = 3'(c); wr_byte_data = 8'hA0 + 8'(c);
      tick();
    end
    for (int c = 0; c < 8; c++) begin
      rd_a_code = 3'(c); rd_b_code = 3'(7 - c); #1;
      check("R2 port A", {8'h00, rd_a_data}, {8'h00, 8'hA0 + 8'(c)});
      check("R2 port B", {8'h00, rd_b_data}, {8'h00, 8'hA7 - 8'(c)});
    end
    mem_peek("R2 A of bank1 at FEF1", 16'hFEF1, 8'hA1);

    // R3: pair reads, odd-coded register in the high byte
    for (int p = 0; p < 4; p++) begin
      rd_pair_code = 2'(p); #1;
      check("R3 pair", rd_pair_data, {8'hA1 + 8'(2 * p), 8'hA0 + 8'(2 * p)});
    end

    // R4: pair write DE = 1234
    wr_pair_en = 1; wr_pair_code = 2'd2; wr_pair_data = 16'h1234; tick();
    rd_a_code = 3'd4; rd_b_code = 3'd5; rd_pair_code = 2'd2; #1;
    check("R4 E low", {8'h00, rd_a_data}, 16'h0034);
    check("R4 D high", {8'h00, rd_b_data}, 16'h0012);
    check("R4 DE", rd_pair_data, 16'h1234);

    // R6: exchange AX<->DE, then null exchange with code 00
    xchg_en = 1; xchg_code = 2'd2; tick();
    rd_pair_code = 2'd0; #1; check("R6 AX after swap", rd_pair_data, 16'h1234);
    rd_pair_code = 2'd2; #1; check("R6 DE after swap", rd_pair_data, 16'hA1A0);
    rd_pair_code = 2'd1; #1; check("R6 BC untouched", rd_pair_data, 16'hA3A2);
    xchg_en = 1; xchg_code = 2'd0; tick();
    rd_pair_code = 2'd0; #1; check("R6 code 00 no change", rd_pair_data, 16'h1234);

    // R5: bank switch and byte write in the same cycle; write lands in old bank
    bank_we = 1; bank_val = 2'd2; wr_byte_en = 1; wr_byte_code = 3'd1; wr_byte_data = 8'h5A;
    tick();
    check("R5 bank now 2", {14'd0, bank_o}, 16'd2);
    mem_peek("R5 bank1 A written", 16'hFEF1, 8'h5A);
    mem_peek("R5 bank2 A untouched", 16'hFEE9, 8'h00);
    rd_a_code = 3'd1; #1;
    check("R5 reg read in bank2", {8'h00, rd_a_data}, 16'h0000);

    // R8: outside the window on both sides
    mem_addr = 16'hFEDF; mem_wdata = 8'hFF; mem_we = 1; #1;
    check("R8 hit low side", {15'd0, mem_hit}, 16'd0);
    check("R8 rdata low side", {8'h00, mem_rdata}, 16'h0000);
    tick();
    mem_addr = 16'hFF00; mem_wdata = 8'hFF; mem_we = 1; #1;
    check("R8 hit high side", {15'd0, mem_hit}, 16'd0);
    tick();
    mem_peek("R8 FEE0 unchanged", 16'hFEE0, 8'h77);
    mem_peek("R8 FEFF unchanged", 16'hFEFF, 8'h22);
    check("R8 hit inside", {15'd0, mem_hit}, 16'd1);

    // R9: same-byte collision, register side wins; different bytes both land
    wr_byte_en = 1; wr_byte_code = 3'd3; wr_byte_data = 8'hC3;
    mem_we = 1; mem_addr = 16'hFEEB; mem_wdata = 8'h3C; tick();
    rd_a_code = 3'd3; #1;
    check("R9 register side wins", {8'h00, rd_a_data}, 16'h00C3);
    wr_byte_en = 1; wr_byte_code = 3'd4; wr_byte_data = 8'hD4;
    mem_we = 1; mem_addr = 16'hFEE0; mem_wdata = 8'hE0; tick();
    rd_a_code = 3'd4; #1;
    check("R9 byte write kept", {8'h00, rd_a_data}, 16'h00D4);
    mem_peek("R9 memory write kept", 16'hFEE0, 8'hE0);

    // R10: pair over byte, exchange over pair (bank 2: AX=0000, BC=C355)
    wr_pair_en = 1; wr_pair_code = 2'd3; wr_pair_data = 16'hBEEF;
    wr_byte_en = 1; wr_byte_code = 3'd6; wr_byte_data = 8'h11; tick();
    rd_pair_code = 2'd3; #1;
    check("R10 pair beats byte", rd_pair_data, 16'hBEEF);
    xchg_en = 1; xchg_code = 2'd1;
    wr_pair_en = 1; wr_pair_code = 2'd0; wr_pair_data = 16'h9999; tick();
    rd_pair_code = 2'd0; #1; check("R10 exchange beats pair AX", rd_pair_data, 16'hC355);
    rd_pair_code = 2'd1; #1; check("R10 exchange beats pair BC", rd_pair_data, 16'h0000);

    // R1: second reset clears everything written above
    do_reset(); #1;
    check("R1 bank after reset", {14'd0, bank_o}, 16'd0);
    mem_peek("R1 FEF1 after reset", 16'hFEF1, 8'h00);
    mem_peek("R1 FEE0 after reset", 16'hFEE0, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule